// File: doc/BRIEF.md
# Cascadable Serial Configuration Memory Reader

This block is the read-out side of a one-bit-wide serial memory from which an FPGA loads its configuration. The FPGA supplies the clock, pulls the chip enable low and releases the combined reset/output-enable pin. The block then presents one stored bit per clock on its data output, starting at address 0. When the last bit has been consumed, the block lets go of the data line and drives its cascade output low. Wiring that output to the chip enable of a second instance makes the second device continue the stream on the same clock and data line, with no gap between the two.

The data line is modelled as a value plus an output-enable, and the system resolves the shared wire. The reset/output-enable pin has a polarity bit: with the default value, a low level resets and a high level enables, and the other value swaps the two levels. The array is preloaded through a valid/ready write port. That port also writes the polarity bit.

Back-pressure on the write port works as follows. A word is accepted on a rising clock edge where both `ld_valid` and `ld_ready` are high. `ld_ready` is low during power-on reset and while the device is actively streaming. While the port is stalled, the sender must hold `ld_kind`, `ld_addr` and `ld_bit` steady. The array depth is a parameter, so a full 1,048,576-bit part can be built and a reduced size can be simulated.

Top module: `cfgmem_reader`

## Requirements
- R1: After `por_n` is released, `ready` stays low for exactly POR_CYCLES rising edges and then stays high until the next power-on reset. During power-on reset the address and the end-of-memory state are cleared and the polarity bit returns to 0.
- R2: A load is accepted on an edge where `ld_valid` and `ld_ready` are both high. `ld_kind`=0 writes `ld_bit` to array address `ld_addr`, and `ld_kind`=1 writes `ld_bit` to the polarity bit. `ld_ready` is high only when `ready` is high and the device is not active, where active means `ce_n` low and the pin at its enable level.
- R3: With polarity bit 0, `rst_oe` low is the reset level and high is the enable level. With polarity bit 1, `rst_oe` high is the reset level and low is the enable level.
- R4: At the reset level, `dout_oe` is low in the same cycle whatever `ce_n` is, and the next edge clears the address to 0 and clears the end-of-memory state.
- R5: On each edge where `ready` is high, `ce_n` is low, the pin is at its enable level and the end of memory has not been reached, the address advances by one.
- R6: `dout_oe` is high exactly when `ready` is high, `ce_n` is low, the pin is at its enable level and the end of memory has not been reached. `dout` then carries the bit at the current address. Address 0 comes first and is visible before the first counting edge.
- R7: With `ce_n` high, `dout_oe` is low and the address is held. Reading resumes at the held address when `ce_n` returns low.
- R8: The counting edge that consumes address DEPTH-1 sets the end-of-memory state. From that edge on, `dout_oe` is low and `ceo_n` is low while `ce_n` stays low.
- R9: Once the end of memory is reached, `ceo_n` follows `ce_n` until the pin reaches the reset level. At the reset level, and whenever the end of memory has not been reached, `ceo_n` is high.
- R10: Two instances chained through `ceo_n` into `ce_n` stream both arrays back to back with no lost or repeated bit, and never both drive the line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| ce_n | input | 1 | Chip enable, active low |
| rst_oe | input | 1 | Combined reset / output-enable pin, polarity set by the polarity bit |
| ld_valid | input | 1 | Load word valid |
| ld_ready | output | 1 | Load port can accept a word |
| ld_kind | input | 1 | 0: array bit, 1: polarity bit |
| ld_addr | input | AW | Array address of the load |
| ld_bit | input | 1 | Value to store |
| dout | output | 1 | Serial data value |
| dout_oe | output | 1 | Serial data driver enable |
| ceo_n | output | 1 | Cascade chip-enable output, active low |
| ready | output | 1 | Power-on reset complete |

## Verification
`dout_oe` and `ceo_n` respond to `ce_n`, `rst_oe` and the stored state within the same cycle. `dout` moves to the next bit one edge after each counting edge. A load takes effect at the edge that accepts it, and `ready` rises on the POR_CYCLES-th edge after release. The bench changes inputs 1 ns after a rising edge. It checks same-cycle results 1 ns later, and a scoreboard compares the resolved data line against the queued expected bits at every falling edge, so every bit is checked in the cycle where it is driven. The falling-edge check also flags any bit that appears when nothing is queued, which catches a missed or doubled handoff.

// File: rtl/cfgmem_pkg.sv
package cfgmem_pkg;

  typedef enum logic {
    LD_ARRAY = 1'b0,
    LD_POL   = 1'b1
  } ld_kind_e;

  // reset level of the combined pin for a given polarity bit
  function automatic logic pin_at_reset(input logic pol, input logic pin);
    return pol ? pin : ~pin;
  endfunction

endpackage

// File: rtl/cfgmem_por.sv
module cfgmem_por #(
  parameter int POR_CYCLES = 16
) (
  input  logic clk,
  input  logic por_n,
  output logic ready_o
);
  localparam int CW = $clog2(POR_CYCLES + 1);
  localparam logic [CW-1:0] LIMIT = CW'(POR_CYCLES);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      cnt_q <= '0;
    end else if (cnt_q != LIMIT) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign ready_o = (cnt_q == LIMIT);
endmodule

// File: rtl/cfgmem_array.sv
module cfgmem_array #(
  parameter int DEPTH = 2048,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic          wr_bit,
  input  logic [AW-1:0] rd_addr,
  output logic          rd_bit
);
  logic [DEPTH-1:0] cells_q;

  always_ff @(posedge clk) begin
    if (wr_en) begin
      cells_q[wr_addr] <= wr_bit;
    end
  end

  assign rd_bit = cells_q[rd_addr];
endmodule

// File: rtl/cfgmem_seq.sv
module cfgmem_seq #(
  parameter int DEPTH = 2048,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          por_n,
  input  logic          ready,
  input  logic          ce_n,
  input  logic          at_reset,
  output logic [AW-1:0] addr_o,
  output logic          done_o
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [AW-1:0] addr_q;
  logic          done_q;
  logic          step;

  assign step = ready && !ce_n && !at_reset && !done_q;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      addr_q <= '0;
      done_q <= 1'b0;
    end else if (!ready || at_reset) begin
      addr_q <= '0;
      done_q <= 1'b0;
    end else if (step) begin
      if (addr_q == LAST) begin
        done_q <= 1'b1;
      end else begin
        addr_q <= addr_q + 1'b1;
      end
    end
  end

  assign addr_o = addr_q;
  assign done_o = done_q;
endmodule

// File: rtl/cfgmem_reader.sv
module cfgmem_reader
  import cfgmem_pkg::*;
#(
  parameter int DEPTH      = 2048,
  parameter int POR_CYCLES = 16,
  parameter int AW         = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          por_n,
  input  logic          ce_n,
  input  logic          rst_oe,
  input  logic          ld_valid,
  output logic          ld_ready,
  input  logic          ld_kind,
  input  logic [AW-1:0] ld_addr,
  input  logic          ld_bit,
  output logic          dout,
  output logic          dout_oe,
  output logic          ceo_n,
  output logic          ready
);
  logic          pol_q;
  logic          at_reset;
  logic          active;
  logic          ld_fire;
  logic          rd_bit;
  logic [AW-1:0] addr_q;
  logic          done_q;

  cfgmem_por #(.POR_CYCLES(POR_CYCLES)) u_por (
    .clk     (clk),
    .por_n   (por_n),
    .ready_o (ready)
  );

  assign at_reset = pin_at_reset(pol_q, rst_oe);
  assign active   = ready && !ce_n && !at_reset;
  assign ld_ready = ready && !active;
  assign ld_fire  = ld_valid && ld_ready;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      pol_q <= 1'b0;
    end else if (ld_fire && ld_kind_e'(ld_kind) == LD_POL) begin
      pol_q <= ld_bit;
    end
  end

  cfgmem_array #(.DEPTH(DEPTH), .AW(AW)) u_array (
    .clk     (clk),
    .wr_en   (ld_fire && ld_kind_e'(ld_kind) == LD_ARRAY),
    .wr_addr (ld_addr),
    .wr_bit  (ld_bit),
    .rd_addr (addr_q),
    .rd_bit  (rd_bit)
  );

  cfgmem_seq #(.DEPTH(DEPTH), .AW(AW)) u_seq (
    .clk      (clk),
    .por_n    (por_n),
    .ready    (ready),
    .ce_n     (ce_n),
    .at_reset (at_reset),
    .addr_o   (addr_q),
    .done_o   (done_q)
  );

  assign dout_oe = active && !done_q;
  assign dout    = dout_oe ? rd_bit : 1'b0;
  assign ceo_n   = (ready && done_q && !at_reset) ? ce_n : 1'b1;
endmodule

// File: rtl/cfgmem_reader_chk.sv
module cfgmem_reader_chk #(
  parameter int DEPTH = 2048,
  parameter int AW    = $clog2(DEPTH)
) (
  input logic          clk,
  input logic          por_n,
  input logic          ce_n,
  input logic          rst_oe,
  input logic          ready,
  input logic          dout_oe,
  input logic          ceo_n,
  input logic          ld_valid,
  input logic          ld_ready,
  input logic          ld_kind,
  input logic          ld_bit,
  input logic [AW-1:0] addr,
  input logic          done,
  input logic          pol
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic rlvl;
  logic live;
  assign rlvl = pol ? rst_oe : !rst_oe;
  assign live = ready && !ce_n && !rlvl && !done;

  // R1
  ready_sticky_chk: assert property (@(posedge clk) disable iff (!por_n)
    ready |=> ready);

  // R2
  load_gate_chk: assert property (@(posedge clk) disable iff (!por_n)
    (!ready || (!ce_n && !rlvl)) |-> !ld_ready);

  // R3
  pol_write_chk: assert property (@(posedge clk) disable iff (!por_n)
    (ld_valid && ld_ready && ld_kind) |=> (pol == $past(ld_bit)));

  // R4
  rst_clear_chk: assert property (@(posedge clk) disable iff (!por_n)
    rlvl |=> (addr == '0 && !done));

  // R5
  advance_chk: assert property (@(posedge clk) disable iff (!por_n)
    (live && addr != LAST) |=> (addr == AW'($past(addr) + 1'b1)));

  // R7
  standby_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
    (ready && ce_n && !rlvl) |=> ($stable(addr) && $stable(done)));

  // R8
  last_bit_chk: assert property (@(posedge clk) disable iff (!por_n)
    (live && addr == LAST) |=> done);

  // R9
  handoff_excl_chk: assert property (@(posedge clk) disable iff (!por_n)
    !(dout_oe && !ceo_n));
endmodule

bind cfgmem_reader cfgmem_reader_chk #(.DEPTH(DEPTH), .AW(AW)) u_chk (
  .clk      (clk),
  .por_n    (por_n),
  .ce_n     (ce_n),
  .rst_oe   (rst_oe),
  .ready    (ready),
  .dout_oe  (dout_oe),
  .ceo_n    (ceo_n),
  .ld_valid (ld_valid),
  .ld_ready (ld_ready),
  .ld_kind  (ld_kind),
  .ld_bit   (ld_bit),
  .addr     (addr_q),
  .done     (done_q),
  .pol      (pol_q)
);

// File: tb/cfgmem_reader_tb.sv
module cfgmem_reader_tb;
  localparam int DEPTH = 64;
  localparam int AW    = 6;
  localparam int POR   = 8;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          por_n = 1'b0;
  logic          ce_n = 1'b1;
  logic          rst_oe = 1'b0;
  logic          ld_valid0 = 1'b0;
  logic          ld_valid1 = 1'b0;
  logic          ld_kind = 1'b0;
  logic [AW-1:0] ld_addr = '0;
  logic          ld_bit = 1'b0;
  logic dout0, oe0, ceo0, rdy0, ldr0;
  logic dout1, oe1, ceo1, rdy1, ldr1;

  cfgmem_reader #(.DEPTH(DEPTH), .POR_CYCLES(POR), .AW(AW)) u_dut (
    .clk(clk), .por_n(por_n), .ce_n(ce_n), .rst_oe(rst_oe),
    .ld_valid(ld_valid0), .ld_ready(ldr0), .ld_kind(ld_kind),
    .ld_addr(ld_addr), .ld_bit(ld_bit),
    .dout(dout0), .dout_oe(oe0), .ceo_n(ceo0), .ready(rdy0));

  cfgmem_reader #(.DEPTH(DEPTH), .POR_CYCLES(POR), .AW(AW)) u_dut_nxt (
    .clk(clk), .por_n(por_n), .ce_n(ceo0), .rst_oe(rst_oe),
    .ld_valid(ld_valid1), .ld_ready(ldr1), .ld_kind(ld_kind),
    .ld_addr(ld_addr), .ld_bit(ld_bit),
    .dout(dout1), .dout_oe(oe1), .ceo_n(ceo1), .ready(rdy1));

  logic bus_val;
  assign bus_val = oe0 ? dout0 : dout1;

  int checks = 0;
  int fails  = 0;
  bit exp_q[$];

  function automatic bit pat(int dev, int a);
    logic [15:0] v;
    v = 16'(a * 29 + dev * 13 + 7) ^ 16'(a >>> 2);
    return ^v;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // driver side of the scoreboard
  task automatic push(int dev, int from, int n);
    for (int i = from; i < from + n; i++) exp_q.push_back(pat(dev, i));
  endtask

  task automatic load(int dev, bit kind, int a, bit b);
    ld_kind = kind;
    ld_addr = AW'(a);
    ld_bit  = b;
    if (dev == 0) ld_valid0 = 1'b1; else ld_valid1 = 1'b1;
    forever begin
      @(negedge clk);
      if ((dev == 0) ? ldr0 : ldr1) break;
    end
    @(posedge clk);
    #1;
    ld_valid0 = 1'b0;
    ld_valid1 = 1'b0;
  endtask

  // monitor side: one bit per falling edge while the line is driven
  always @(negedge clk) begin
    if (por_n && (oe0 || oe1)) begin
      chk(!(oe0 && oe1), "R10 single driver", int'(oe0) + int'(oe1), 1);
      if (exp_q.size() == 0) begin
        chk(1'b0, "R6 unexpected bit on line", int'(bus_val), -1);
      end else begin
        bit e;
        e = exp_q.pop_front();
        chk(bus_val == e, "R6 R10 stream bit", int'(bus_val), int'(e));
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    report();
  end

  initial begin
    #2;
    chk(rdy0 == 1'b0, "R1 ready low in reset", rdy0, 0);
    chk(oe0 == 1'b0 && oe1 == 1'b0, "R1 line free in reset", oe0 | oe1, 0);
    chk(ceo0 == 1'b1, "R9 cascade high in reset", ceo0, 1);
    tick(3);
    por_n = 1'b1;
    tick(POR - 1);
    chk(rdy0 == 1'b0, "R1 ready still low", rdy0, 0);
    tick(1);
    chk(rdy0 && rdy1, "R1 ready after count", rdy0 & rdy1, 1);
    chk(ldr0 == 1'b1, "R2 load ready idle", ldr0, 1);

    for (int d = 0; d < 2; d++)
      for (int a = 0; a < DEPTH; a++)
        load(d, 1'b0, a, pat(d, a));

    // enable level, still in standby
    rst_oe = 1'b1;
    #1;
    chk(oe0 == 1'b0, "R7 standby no drive", oe0, 0);
    push(0, 0, 20);
    ce_n = 1'b0;
    #1;
    chk(oe0 == 1'b1, "R6 drive on enable", oe0, 1);
    chk(ldr0 == 1'b0, "R2 back-pressure while active", ldr0, 0);
    tick(20);
    ce_n = 1'b1;
    #1;
    chk(oe0 == 1'b0, "R7 standby mid stream", oe0, 0);
    tick(5);
    chk(exp_q.size() == 0, "R7 no bits in standby", exp_q.size(), 0);

    push(0, 20, DEPTH - 20);
    push(1, 0, DEPTH);
    ce_n = 1'b0;
    tick(DEPTH - 20);
    chk(ceo0 == 1'b0, "R8 cascade low at end", ceo0, 0);
    chk(oe0 == 1'b0, "R8 first releases line", oe0, 0);
    chk(oe1 == 1'b1, "R10 second takes line", oe1, 1);
    chk(exp_q.size() == DEPTH, "R10 handoff point", exp_q.size(), DEPTH);
    tick(DEPTH);
    chk(oe1 == 1'b0 && ceo1 == 1'b0, "R8 second at end", {oe1, ceo1}, 0);
    chk(exp_q.size() == 0, "R10 all bits seen", exp_q.size(), 0);

    ce_n = 1'b1;
    #1;
    chk(ceo0 == 1'b1, "R9 cascade follows ce high", ceo0, 1);
    tick(2);
    ce_n = 1'b0;
    #1;
    chk(ceo0 == 1'b0, "R9 cascade follows ce low", ceo0, 0);
    chk(oe0 == 1'b0, "R8 stays released", oe0, 0);
    tick(3);

    rst_oe = 1'b0;
    #1;
    chk(ceo0 == 1'b1, "R9 cascade high at reset", ceo0, 1);
    chk(oe0 == 1'b0, "R4 no drive at reset", oe0, 0);
    tick(1);
    push(0, 0, 10);
    rst_oe = 1'b1;
    #1;
    chk(oe0 == 1'b1, "R4 restart after reset", oe0, 1);
    tick(10);
    rst_oe = 1'b0;
    #1;
    chk(oe0 == 1'b0, "R4 reset mid stream with ce low", oe0, 0);
    tick(1);
    push(0, 0, 5);
    rst_oe = 1'b1;
    tick(5);
    ce_n = 1'b1;
    #1;
    chk(exp_q.size() == 0, "R4 restart from address 0", exp_q.size(), 0);

    // inverted polarity
    rst_oe = 1'b0;
    tick(1);
    load(0, 1'b1, 0, 1'b1);
    load(1, 1'b1, 0, 1'b1);
    push(0, 0, 6);
    ce_n = 1'b0;
    #1;
    chk(oe0 == 1'b1, "R3 low level enables when inverted", oe0, 1);
    tick(6);
    rst_oe = 1'b1;
    #1;
    chk(oe0 == 1'b0, "R3 high level resets when inverted", oe0, 0);
    tick(1);
    chk(exp_q.size() == 0, "R3 inverted stream complete", exp_q.size(), 0);

    report();
  end
endmodule